// File: doc/BRIEF.md
# Lockable Thermal Trip-Point Register Bank

This block holds two programmable 8-bit temperature thresholds and watches an 8-bit temperature value against both of them. Each channel keeps a sticky event flag that is set when the temperature moves from below its threshold to at or above it. Software clears a flag by writing 1 to it. The two flags are ORed onto an interrupt pin. A lock bit freezes both thresholds so that code running later cannot move them.

Software programs the block over a plain word-addressed register bus with two registers. The trip register is at word address 0 and the event register is at word address 1. Read data follows `bus_addr` combinationally. `bus_rd` marks a read access, and `bus_wr` marks a write, which takes effect on the next rising clock edge. Setting the lock is one write. Clearing the lock takes a four-write key sequence on consecutive bus accesses. The temperature input is sampled on every clock and has no handshake.

Top module: `thermal_trip_regs`

## Requirements
- R1: After reset both registers read 0x00000000 and `irq_out` is 0. While the thresholds are 0, no event is raised.
- R2: The trip register (address 0) has the channel-0 threshold in bits 15:8, the channel-1 threshold in bits 7:0 and the lock flag in bit 31. While unlocked, a write stores both thresholds and reads back the stored values.
- R3: The event register (address 1) has the channel-0 event in bit 4 and the channel-1 event in bit 5. A bit is set when `temp_in >= threshold` becomes true after having been false, and it is readable one clock after the edge that samples the rising temperature. A falling temperature never sets a bit.
- R4: Event bits are write-1-to-clear. Writing 0 to a bit leaves it unchanged, and a set bit stays set until it is cleared.
- R5: If a crossing and a clear hit the same event bit in the same cycle, the bit ends up set.
- R6: `irq_out` is 1 exactly when at least one event bit is set.
- R7: Writing 1 to bit 31 of the trip register sets the lock. While the lock is set, threshold writes are ignored, and writing 0 to bit 31 does not clear the lock.
- R8: The lock clears after four consecutive writes of data 0x04C1C202 to addresses 0, 1, 1, 0 in that order. After that, threshold writes take effect again. The key writes to address 0 do not change the thresholds while the lock is set.
- R9: Any other bus access in the middle of the key sequence aborts it. This includes a read (`bus_rd`) of any address, a write to any other address, or a write with any other data. A key write to address 0 that breaks the sequence starts a new sequence at step one.
- R10: Reserved bits read as 0 and ignore writes. Addresses other than 0 and 1 read as 0, and writes to them have no effect.
- R11: A new threshold is used from the next comparison on. If lowering a threshold makes the comparison go from false to true, the event is set one clock after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Word address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, marks a read access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| temp_in | input | 8 | Current temperature code |
| irq_out | output | 1 | OR of the two event bits |

## Verification
Two situations are the hardest to reach from the ports.

The first is a crossing and a write-1-to-clear arriving in the same clock. The bench first drops the temperature below the threshold. Then, on one falling edge, it raises the temperature and presents the clearing write together, so both act on the same rising edge.

The second is a key sequence that is broken by a key write to address 0, which must restart the sequence rather than abandon it. The bench sends two correct steps, then the step-one write again, then the full remainder, and only a restarted sequence leaves the lock clear. A bus read in the middle of an otherwise perfect sequence checks that reads also count as interruptions.

// File: rtl/thermal_trip_pkg.sv
`timescale 1ns/1ps
package thermal_trip_pkg;
  localparam int TT_ADDR_W   = 4;
  localparam int TT_DATA_W   = 32;
  localparam int TT_TEMP_W   = 8;
  localparam int TT_N_TRIP   = 2;
  localparam int TT_LOCK_BIT = 31;
  localparam int TT_EVT_LSB  = 4;
  localparam logic [31:0] TT_UNLOCK_KEY = 32'h04C1_C202;

  // progress through the four-write unlock key
  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_GOT_A  = 2'd1,
    SEQ_GOT_AB = 2'd2,
    SEQ_GOT_ABB = 2'd3
  } unlock_step_e;
endpackage

// File: rtl/thermal_trip_cross.sv
`timescale 1ns/1ps
// Detects a low-to-high transition of (temp >= threshold), sampled each clock.
module thermal_trip_cross #(
  parameter int TEMP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TEMP_W-1:0] temp_in,
  input  logic [TEMP_W-1:0] thresh,
  output logic              rise
);
  logic at_or_above;
  logic above_q;

  assign at_or_above = (temp_in >= thresh);

  // Reset to "above" so that no event fires before a real low phase is seen.
  always_ff @(posedge clk) begin
    if (!rst_n) above_q <= 1'b1;
    else        above_q <= at_or_above;
  end

  assign rise = at_or_above & ~above_q;
endmodule

// File: rtl/thermal_trip_unlock.sv
`timescale 1ns/1ps
// Tracks the key sequence A, B, B, A on consecutive bus accesses.
module thermal_trip_unlock
  import thermal_trip_pkg::*;
#(
  parameter int ADDR_W = TT_ADDR_W,
  parameter int DATA_W = TT_DATA_W,
  parameter int ADDR_A = 0,
  parameter int ADDR_B = 1,
  parameter logic [DATA_W-1:0] KEY = DATA_W'(TT_UNLOCK_KEY)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_wr,
  input  logic              acc_rd,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic              unlock
);
  localparam logic [ADDR_W-1:0] A_CODE = ADDR_W'(ADDR_A);
  localparam logic [ADDR_W-1:0] B_CODE = ADDR_W'(ADDR_B);

  unlock_step_e step_q, step_d;
  logic [ADDR_W-1:0] want_addr;
  logic any_access, key_write, step_hit, first_hit;

  always_comb begin
    unique case (step_q)
      SEQ_IDLE:   want_addr = A_CODE;
      SEQ_GOT_A:  want_addr = B_CODE;
      SEQ_GOT_AB: want_addr = B_CODE;
      default:    want_addr = A_CODE;
    endcase
  end

  assign any_access = acc_wr | acc_rd;
  assign key_write  = acc_wr & ~acc_rd & (acc_wdata == KEY);
  assign step_hit   = key_write & (acc_addr == want_addr);
  assign first_hit  = key_write & (acc_addr == A_CODE);

  always_comb begin
    step_d = step_q;
    if (any_access) begin
      if (step_hit) begin
        unique case (step_q)
          SEQ_IDLE:   step_d = SEQ_GOT_A;
          SEQ_GOT_A:  step_d = SEQ_GOT_AB;
          SEQ_GOT_AB: step_d = SEQ_GOT_ABB;
          default:    step_d = SEQ_IDLE;
        endcase
      end else if (first_hit) begin
        step_d = SEQ_GOT_A;
      end else begin
        step_d = SEQ_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) step_q <= SEQ_IDLE;
    else        step_q <= step_d;
  end

  assign unlock = step_hit & (step_q == SEQ_GOT_ABB);
endmodule

// File: rtl/thermal_trip_rdmap.sv
`timescale 1ns/1ps
// Read-data assembly; unmapped addresses and reserved bits return zero.
module thermal_trip_rdmap #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int TEMP_W    = 8,
  parameter int N_TRIP    = 2,
  parameter int LOCK_BIT  = 31,
  parameter int EVT_LSB   = 4,
  parameter int ADDR_TRIP = 0,
  parameter int ADDR_EVT  = 1
) (
  input  logic [ADDR_W-1:0]              rd_addr,
  input  logic                           lock,
  input  logic [N_TRIP-1:0][TEMP_W-1:0]  thr,
  input  logic [N_TRIP-1:0]              evt,
  output logic [DATA_W-1:0]              rd_data
);
  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(ADDR_TRIP)) begin
      rd_data[LOCK_BIT] = lock;
      for (int i = 0; i < N_TRIP; i++)
        rd_data[(N_TRIP-1-i)*TEMP_W +: TEMP_W] = thr[i];
    end else if (rd_addr == ADDR_W'(ADDR_EVT)) begin
      for (int i = 0; i < N_TRIP; i++)
        rd_data[EVT_LSB+i] = evt[i];
    end
  end
endmodule

// File: rtl/thermal_trip_regs.sv
`timescale 1ns/1ps
module thermal_trip_regs
  import thermal_trip_pkg::*;
#(
  parameter int ADDR_W    = TT_ADDR_W,
  parameter int DATA_W    = TT_DATA_W,
  parameter int TEMP_W    = TT_TEMP_W,
  parameter int N_TRIP    = TT_N_TRIP,
  parameter int LOCK_BIT  = TT_LOCK_BIT,
  parameter int EVT_LSB   = TT_EVT_LSB,
  parameter int ADDR_TRIP = 0,
  parameter int ADDR_EVT  = 1,
  parameter logic [DATA_W-1:0] UNLOCK_KEY = DATA_W'(TT_UNLOCK_KEY)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [TEMP_W-1:0] temp_in,
  output logic              irq_out
);
  localparam logic [ADDR_W-1:0] TRIP_CODE = ADDR_W'(ADDR_TRIP);
  localparam logic [ADDR_W-1:0] EVT_CODE  = ADDR_W'(ADDR_EVT);

  logic                          lock_q;
  logic [N_TRIP-1:0][TEMP_W-1:0] thr_q;
  logic [N_TRIP-1:0]             evt_q;
  logic [N_TRIP-1:0]             rise;
  logic                          wr_trip, wr_evt, unlock;

  assign wr_trip = bus_wr & (bus_addr == TRIP_CODE);
  assign wr_evt  = bus_wr & (bus_addr == EVT_CODE);

  thermal_trip_unlock #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .ADDR_A(ADDR_TRIP), .ADDR_B(ADDR_EVT), .KEY(UNLOCK_KEY)
  ) u_unlock (
    .clk(clk), .rst_n(rst_n),
    .acc_wr(bus_wr), .acc_rd(bus_rd),
    .acc_addr(bus_addr), .acc_wdata(bus_wdata),
    .unlock(unlock)
  );

  // lock: set by a 1 in the lock bit, cleared only by the key sequence
  always_ff @(posedge clk) begin
    if (!rst_n)                               lock_q <= 1'b0;
    else if (unlock)                          lock_q <= 1'b0;
    else if (wr_trip && bus_wdata[LOCK_BIT])  lock_q <= 1'b1;
  end

  // thresholds: writable only while unlocked
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_q <= '0;
    end else if (wr_trip && !lock_q) begin
      for (int i = 0; i < N_TRIP; i++)
        thr_q[i] <= bus_wdata[(N_TRIP-1-i)*TEMP_W +: TEMP_W];
    end
  end

  // crossing detectors, one per channel
  for (genvar g = 0; g < N_TRIP; g++) begin : g_trip
    thermal_trip_cross #(.TEMP_W(TEMP_W)) u_cross (
      .clk(clk), .rst_n(rst_n),
      .temp_in(temp_in), .thresh(thr_q[g]),
      .rise(rise[g])
    );
  end

  // sticky events, write-1-to-clear, hardware set wins
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_q <= '0;
    end else begin
      for (int i = 0; i < N_TRIP; i++)
        evt_q[i] <= rise[i] | (evt_q[i] & ~(wr_evt & bus_wdata[EVT_LSB+i]));
    end
  end

  assign irq_out = |evt_q;

  thermal_trip_rdmap #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TEMP_W(TEMP_W), .N_TRIP(N_TRIP),
    .LOCK_BIT(LOCK_BIT), .EVT_LSB(EVT_LSB),
    .ADDR_TRIP(ADDR_TRIP), .ADDR_EVT(ADDR_EVT)
  ) u_rdmap (
    .rd_addr(bus_addr), .lock(lock_q), .thr(thr_q), .evt(evt_q),
    .rd_data(bus_rdata)
  );
endmodule

// File: rtl/thermal_trip_chk.sv
`timescale 1ns/1ps
module thermal_trip_chk #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int TEMP_W    = 8,
  parameter int N_TRIP    = 2,
  parameter int EVT_LSB   = 4,
  parameter int ADDR_TRIP = 0,
  parameter int ADDR_EVT  = 1,
  parameter logic [DATA_W-1:0] UNLOCK_KEY = '0
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [ADDR_W-1:0]             bus_addr,
  input logic                          bus_wr,
  input logic [DATA_W-1:0]             bus_wdata,
  input logic [DATA_W-1:0]             bus_rdata,
  input logic [TEMP_W-1:0]             temp_in,
  input logic                          irq_out,
  input logic                          lock_q,
  input logic [N_TRIP-1:0][TEMP_W-1:0] thr_q,
  input logic [N_TRIP-1:0]             evt_q
);
  localparam logic [ADDR_W-1:0] TRIP_CODE = ADDR_W'(ADDR_TRIP);
  localparam logic [ADDR_W-1:0] EVT_CODE  = ADDR_W'(ADDR_EVT);

  AST_LOCKED_THR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && bus_wr && bus_addr == TRIP_CODE) |=> $stable(thr_q)); // R7

  AST_UNLOCK_BY_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_q) |-> $past(bus_wr && bus_addr == TRIP_CODE && bus_wdata == UNLOCK_KEY)); // R8

  AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != TRIP_CODE && bus_addr != EVT_CODE) |-> bus_rdata == '0); // R10

  AST_IRQ_RISES_WITH_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> $countones(evt_q) > 0); // R6

  for (genvar g = 0; g < N_TRIP; g++) begin : g_ch
    AST_EVT_NEEDS_CROSSING: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(evt_q[g]) |-> ($past(temp_in >= thr_q[g]) && !$past(temp_in >= thr_q[g], 2))); // R3

    AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_q[g] && !(bus_wr && bus_addr == EVT_CODE && bus_wdata[EVT_LSB+g])) |=> evt_q[g]); // R4
  end
endmodule

bind thermal_trip_regs thermal_trip_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TEMP_W(TEMP_W), .N_TRIP(N_TRIP),
  .EVT_LSB(EVT_LSB), .ADDR_TRIP(ADDR_TRIP), .ADDR_EVT(ADDR_EVT),
  .UNLOCK_KEY(UNLOCK_KEY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .temp_in(temp_in),
  .irq_out(irq_out), .lock_q(lock_q), .thr_q(thr_q), .evt_q(evt_q)
);

// File: tb/sim_thermal_trip_regs.sv
`timescale 1ns/1ps
module sim_thermal_trip_regs;
  localparam logic [3:0]  A_TRIP = 4'd0;
  localparam logic [3:0]  A_EVT  = 4'd1;
  localparam logic [31:0] KEY    = 32'h04C1_C202;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  temp_in = '0;
  logic        irq_out;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  thermal_trip_regs u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .temp_in(temp_in), .irq_out(irq_out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic peek(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd_access(input logic [3:0] a);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic set_temp(input logic [7:0] v);
    @(negedge clk);
    temp_in = v;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    repeat (3) @(negedge clk);
    peek(A_TRIP, d); check("R1 trip reg after reset", d, 32'h0);
    peek(A_EVT, d);  check("R1 event reg after reset", d, 32'h0);
    check("R1 irq after reset", {31'b0, irq_out}, 32'h0);
  endtask

  task automatic t_fields();
    logic [31:0] d;
    wr(A_TRIP, 32'h7FFF_3C5A);
    peek(A_TRIP, d); check("R2/R10 thresholds stored, reserved zero", d, 32'h0000_3C5A);
    wr(4'd2, 32'hFFFF_FFFF);
    peek(4'd2, d); check("R10 unmapped address reads zero", d, 32'h0);
    peek(A_TRIP, d); check("R10 unmapped write leaves trip reg", d, 32'h0000_3C5A);
  endtask

  task automatic t_crossing();
    logic [31:0] d;
    wr(A_TRIP, 32'h0000_4080);       // ch0 = 0x40, ch1 = 0x80
    set_temp(8'h10);
    peek(A_EVT, d); check("R3 below both thresholds", d, 32'h0);
    set_temp(8'h40);
    peek(A_EVT, d); check("R3 ch0 crossing at equality", d, 32'h10);
    check("R6 irq with ch0 set", {31'b0, irq_out}, 32'h1);
    set_temp(8'h90);
    peek(A_EVT, d); check("R3 ch1 crossing", d, 32'h30);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    wr(A_EVT, 32'h0);
    peek(A_EVT, d); check("R4 writing zero keeps events", d, 32'h30);
    wr(A_EVT, 32'h10);
    peek(A_EVT, d); check("R4 clear ch0 only", d, 32'h20);
    check("R6 irq with ch1 still set", {31'b0, irq_out}, 32'h1);
    wr(A_EVT, 32'h20);
    peek(A_EVT, d); check("R4 clear ch1", d, 32'h0);
    check("R6 irq low with no events", {31'b0, irq_out}, 32'h0);
    set_temp(8'h10);
    peek(A_EVT, d); check("R3 falling sets nothing", d, 32'h0);
  endtask

  task automatic t_set_wins();
    logic [31:0] d;
    set_temp(8'h50);
    set_temp(8'h10);
    peek(A_EVT, d); check("R3 ch0 set by earlier rise", d, 32'h10);
    @(negedge clk);
    temp_in = 8'h50; bus_addr = A_EVT; bus_wdata = 32'h10; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
    peek(A_EVT, d); check("R5 set beats same-cycle clear", d, 32'h10);
    wr(A_EVT, 32'h30);
    peek(A_EVT, d); check("R4 cleared after set-wins", d, 32'h0);
  endtask

  task automatic t_thr_change();
    logic [31:0] d;
    wr(A_TRIP, 32'h0000_6080);       // ch0 0x60 above temp 0x50
    @(negedge clk);
    peek(A_EVT, d); check("R11 raised threshold, no event", d, 32'h0);
    wr(A_TRIP, 32'h0000_5080);       // ch0 0x50 now equals temp
    peek(A_EVT, d); check("R11 no event in write cycle", d, 32'h0);
    @(negedge clk);
    peek(A_EVT, d); check("R11 event one clock after lowering", d, 32'h10);
    wr(A_EVT, 32'h30);
  endtask

  task automatic t_lock();
    logic [31:0] d;
    wr(A_TRIP, 32'h8000_2233);
    peek(A_TRIP, d); check("R7 lock set with fields", d, 32'h8000_2233);
    wr(A_TRIP, 32'h0000_5566);
    peek(A_TRIP, d); check("R7 locked: write ignored, lock kept", d, 32'h8000_2233);
  endtask

  task automatic t_broken_seq();
    logic [31:0] d;
    wr(A_TRIP, KEY); wr(A_EVT, KEY); rd_access(A_EVT); wr(A_EVT, KEY); wr(A_TRIP, KEY);
    peek(A_TRIP, d); check("R9 read inside sequence aborts", d, 32'h8000_2233);
    wr(A_TRIP, KEY); wr(A_EVT, KEY); wr(A_EVT, KEY ^ 32'h1); wr(A_TRIP, KEY);
    peek(A_TRIP, d); check("R9 wrong data aborts", d, 32'h8000_2233);
    wr(A_TRIP, KEY); wr(A_EVT, KEY); wr(4'd2, KEY); wr(A_EVT, KEY); wr(A_TRIP, KEY);
    peek(A_TRIP, d); check("R9 other address aborts", d, 32'h8000_2233);
  endtask

  task automatic t_restart_seq();
    logic [31:0] d;
    wr(A_TRIP, KEY); wr(A_EVT, KEY); wr(A_TRIP, KEY);
    wr(A_EVT, KEY); wr(A_EVT, KEY); wr(A_TRIP, KEY);
    peek(A_TRIP, d); check("R9 key write to A restarts sequence", d, 32'h0000_2233);
    wr(A_TRIP, 32'h0000_1111);
    peek(A_TRIP, d); check("R8 writable after unlock", d, 32'h0000_1111);
  endtask

  task automatic t_unlock();
    logic [31:0] d;
    wr(A_TRIP, 32'h8000_0000);
    wr(A_TRIP, KEY); wr(A_EVT, KEY); wr(A_EVT, KEY);
    peek(A_TRIP, d); check("R8 still locked after three steps", d, 32'h8000_0000);
    wr(A_TRIP, KEY);
    peek(A_TRIP, d); check("R8 unlocked after four steps", d, 32'h0);
    wr(A_EVT, 32'hFFFF_FFFF);
    peek(A_EVT, d); check("R10 event reserved bits zero", d, 32'h0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fields();
    t_crossing();
    t_w1c();
    t_set_wins();
    t_thr_change();
    t_lock();
    t_broken_seq();
    t_restart_seq();
    t_unlock();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog (all R): actual=timeout expected=complete");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule